// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control sequencer of a small 4-bit processor. A 64-word microcode store sits behind a 6-bit microaddress register. At every clock the sequencer works out the next microaddress and reads the matching microword. The control field of that microword drives the datapath.

The next microaddress comes from a four-way selector. Its inputs are the current address plus one, a jump target carried in the microword, the 4-bit opcode widened to six bits, and a constant restart address that leads back to instruction fetch. A pair of per-bit override gates sits between the microword's selector code and the selector. They act only while a microword flagged as conditional is active, which happens only in the conditional jump routine. During that step a clear carry forces the restart choice. A set carry lets the normal jump go through.

Instruction fetch uses the two top entries of the store. The first fetch step at 0x3F jumps to 0x3E. The second fetch step at 0x3E dispatches on the opcode, so opcode n enters its routine at microaddress n. Routines that need a second or third step continue from 0x10 upward, and every routine ends by restarting fetch.

Top module: `ucode_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the microaddress is 0x3F. In that state control bit 5 (memory read) and control bit 8 (program counter advance) are both 1.
- R2: Microaddress 0x3F is always followed by 0x3E. At 0x3E control bit 7 (instruction register load) is 1, and at every other step it is 0.
- R3: The step after 0x3E is the opcode zero-extended to six bits. The opcode input has no effect on the address sequence at any other step.
- R4: For opcodes 0x0 to 0x7 (ALU operations) the sequence is 0x3F, 0x3E, n, 0x10+n, 0x3F. At step 0x10+n, control bit 4 (ALU enable) is 1 and control bits 3:0 (ALU function) equal n.
- R5: For opcode 0x8 (unconditional jump) the sequence is 0x3F, 0x3E, 0x08, 0x1F, 0x20, 0x3F.
- R6: For opcode 0x9 (conditional jump) with carry 1 the sequence is 0x3F, 0x3E, 0x09, 0x21, 0x22, 0x3F. With carry 0 it is 0x3F, 0x3E, 0x09, 0x3F. Control bit 9 (program counter load) is 1 only at 0x20 and 0x22.
- R7: The carry input affects the next address only while the current microaddress is 0x09.
- R8: Opcode 0xA (swap) runs 0x3F, 0x3E, 0x0A, 0x18, 0x3F. Opcode 0xB (copy) runs 0x3F, 0x3E, 0x0B, 0x3F.
- R9: Opcode 0xC (memory write) runs 0x3F, 0x3E, 0x0C, 0x19, 0x1A, 0x3F. Opcode 0xD (memory read) runs 0x3F, 0x3E, 0x0D, 0x1B, 0x1C, 0x3F. Control bit 6 (memory write) is 1 only at 0x1A.
- R10: Opcode 0xE (input) runs 0x3F, 0x3E, 0x0E, 0x1D, 0x3F. Opcode 0xF (output) runs 0x3F, 0x3E, 0x0F, 0x1E, 0x3F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Instruction opcode from the datapath |
| carry | input | 1 | Carry flag from the datapath |
| upc | output | 6 | Current microaddress |
| ctrl | output | 18 | Datapath control field of the current microword |

## Verification
The bench builds the sequencer with its default parameters: a 6-bit microaddress, a 4-bit opcode and an 18-bit control field. With these values all sixteen opcodes can be dispatched, so every routine in the store and both fetch steps are walked in full. The conditional jump is driven with carry set and with carry clear. While each instruction runs, the opcode and carry inputs are changed after their sampling step, which shows that they are only sampled at that one step.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UA_W   = 6;
  localparam int OP_W   = 4;
  localparam int CTRL_W = 18;

  typedef enum logic [1:0] {
    NX_INC   = 2'd0,
    NX_JMP   = 2'd1,
    NX_OPC   = 2'd2,
    NX_FETCH = 2'd3
  } nx_sel_e;

  typedef struct packed {
    logic              cond;
    nx_sel_e           sel;
    logic [UA_W-1:0]   jmp;
    logic [CTRL_W-1:0] ctrl;
  } uword_t;

  localparam int UW_W = $bits(uword_t);

  localparam logic [UA_W-1:0] FETCH_A = 6'h3F;
  localparam logic [UA_W-1:0] FETCH_B = 6'h3E;

  // control field bit positions
  localparam int CB_ALU_EN = 4;
  localparam int CB_MEM_RD = 5;
  localparam int CB_MEM_WR = 6;
  localparam int CB_IR_LD  = 7;
  localparam int CB_PC_INC = 8;
  localparam int CB_PC_LD  = 9;
  localparam int CB_SWAP   = 10;
  localparam int CB_COPY   = 11;
  localparam int CB_IN_EN  = 12;
  localparam int CB_OUT_EN = 13;
  localparam int CB_A_LD   = 14;
  localparam int CB_B_LD   = 15;
  localparam int CB_FLG_LD = 16;
  localparam int CB_MAR_LD = 17;

  // Computes the microword stored at address a.
  function automatic uword_t ucode_entry(input logic [UA_W-1:0] a);
    uword_t w;
    w      = '0;
    w.sel  = NX_FETCH;
    if (a < 6'h08) begin
      w.sel = NX_JMP;
      w.jmp = 6'h10 | a;
      w.ctrl[CB_B_LD] = 1'b1;
    end else if (a >= 6'h10 && a < 6'h18) begin
      w.ctrl[3:0]       = a[3:0];
      w.ctrl[CB_ALU_EN] = 1'b1;
      w.ctrl[CB_A_LD]   = 1'b1;
      w.ctrl[CB_FLG_LD] = (a[3:0] < 4'h4);
    end else begin
      case (a)
        6'h08: begin w.sel = NX_JMP; w.jmp = 6'h1F; end
        6'h09: begin w.sel = NX_JMP; w.jmp = 6'h21; w.cond = 1'b1; end
        6'h0A: begin w.sel = NX_JMP; w.jmp = 6'h18; w.ctrl[CB_B_LD] = 1'b1; end
        6'h0B: w.ctrl[CB_COPY] = 1'b1;
        6'h0C: begin w.sel = NX_JMP; w.jmp = 6'h19; end
        6'h0D: begin w.sel = NX_JMP; w.jmp = 6'h1B; end
        6'h0E: begin w.sel = NX_JMP; w.jmp = 6'h1D; end
        6'h0F: begin w.sel = NX_JMP; w.jmp = 6'h1E; end
        6'h18: w.ctrl[CB_SWAP] = 1'b1;
        6'h19, 6'h1B, 6'h1F, 6'h21: begin
          w.sel = NX_INC;
          w.ctrl[CB_MAR_LD] = 1'b1;
          w.ctrl[CB_MEM_RD] = 1'b1;
        end
        6'h1A: w.ctrl[CB_MEM_WR] = 1'b1;
        6'h1C: begin w.ctrl[CB_MEM_RD] = 1'b1; w.ctrl[CB_A_LD] = 1'b1; end
        6'h1D: begin w.ctrl[CB_IN_EN] = 1'b1; w.ctrl[CB_A_LD] = 1'b1; end
        6'h1E: w.ctrl[CB_OUT_EN] = 1'b1;
        6'h20, 6'h22: w.ctrl[CB_PC_LD] = 1'b1;
        6'h3E: begin w.sel = NX_OPC; w.ctrl[CB_IR_LD] = 1'b1; end
        6'h3F: begin
          w.sel = NX_JMP;
          w.jmp = FETCH_B;
          w.ctrl[CB_MEM_RD] = 1'b1;
          w.ctrl[CB_PC_INC] = 1'b1;
        end
        default: w.sel = NX_FETCH;
      endcase
    end
    return w;
  endfunction
endpackage

// File: rtl/ucode_rom.sv
module ucode_rom #(
  parameter int AW = useq_pkg::UA_W,
  parameter int DW = useq_pkg::UW_W
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DW'(useq_pkg::ucode_entry(useq_pkg::UA_W'(i)));
    end
  end

  always_ff @(posedge clk) begin
    data <= mem[addr];
  end
endmodule

// File: rtl/useq_next.sv
module useq_next #(
  parameter int AW = useq_pkg::UA_W,
  parameter int OW = useq_pkg::OP_W
) (
  input  logic [AW-1:0] upc,
  input  logic [1:0]    sel,
  input  logic [AW-1:0] jmp,
  input  logic          cond,
  input  logic [OW-1:0] opcode,
  input  logic          carry,
  input  logic [AW-1:0] restart,
  output logic [AW-1:0] nxt
);
  localparam int PAD_W = AW - OW;

  logic [1:0]    sel_eff;
  logic [AW-1:0] opc_ext;
  logic          force_fetch;

  assign force_fetch = cond & ~carry;

  // override pair: one gate per select bit, forcing the restart code
  for (genvar b = 0; b < 2; b++) begin : g_ovr
    assign sel_eff[b] = force_fetch ? 1'b1 : sel[b];
  end

  if (PAD_W > 0) begin : g_pad
    assign opc_ext = {{PAD_W{1'b0}}, opcode};
  end else begin : g_nopad
    assign opc_ext = opcode[AW-1:0];
  end

  always_comb begin
    case (sel_eff)
      2'd0:    nxt = upc + 1'b1;
      2'd1:    nxt = jmp;
      2'd2:    nxt = opc_ext;
      default: nxt = restart;
    endcase
  end
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq #(
  parameter int ADDR_W = useq_pkg::UA_W,
  parameter int OPC_W  = useq_pkg::OP_W,
  parameter int CTL_W  = useq_pkg::CTRL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              carry,
  output logic [ADDR_W-1:0] upc,
  output logic [CTL_W-1:0]  ctrl
);
  import useq_pkg::*;

  localparam int WORD_W = UW_W;

  logic [ADDR_W-1:0] upc_q;
  logic [ADDR_W-1:0] nxt;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rom_q;
  uword_t            uw;

  assign uw      = uword_t'(rom_q);
  assign rd_addr = rst ? FETCH_A : nxt;

  useq_next #(.AW(ADDR_W), .OW(OPC_W)) i_next (
    .upc     (upc_q),
    .sel     (uw.sel),
    .jmp     (uw.jmp),
    .cond    (uw.cond),
    .opcode  (opcode),
    .carry   (carry),
    .restart (FETCH_A),
    .nxt     (nxt)
  );

  ucode_rom #(.AW(ADDR_W), .DW(WORD_W)) i_rom (
    .clk  (clk),
    .addr (rd_addr),
    .data (rom_q)
  );

  always_ff @(posedge clk) begin
    if (rst) upc_q <= FETCH_A;
    else     upc_q <= nxt;
  end

  assign upc  = upc_q;
  assign ctrl = uw.ctrl;
endmodule

// File: rtl/ucode_seq_chk.sv
module ucode_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] opcode,
  input logic       carry,
  input logic [5:0] upc,
  input logic [17:0] ctrl
);
  // R1
  reset_start_chk: assert property (@(posedge clk) rst |=> upc == 6'h3F);
  // R2
  fetch_order_chk: assert property (@(posedge clk) disable iff (rst)
    upc == 6'h3F |=> upc == 6'h3E);
  // R3
  dispatch_chk: assert property (@(posedge clk) disable iff (rst)
    upc == 6'h3E |=> upc == {2'b00, $past(opcode)});
  // R4
  alu_end_chk: assert property (@(posedge clk) disable iff (rst)
    (upc >= 6'h10 && upc <= 6'h17) |=> upc == 6'h3F);
  // R6
  jmpc_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (upc == 6'h09 && !carry) |=> upc == 6'h3F);
  // R6
  jmpc_take_chk: assert property (@(posedge clk) disable iff (rst)
    (upc == 6'h09 && carry) |=> upc == 6'h21);
  // R9
  mem_wr_step_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl[6] |-> upc == 6'h1A);
endmodule

bind ucode_seq ucode_seq_chk i_seq_chk (
  .clk(clk), .rst(rst), .opcode(opcode), .carry(carry), .upc(upc), .ctrl(ctrl)
);

// File: tb/test_ucode_seq.sv
module test_ucode_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] opcode = 4'h0;
  logic       carry = 1'b0;
  logic [5:0] upc;
  logic [17:0] ctrl;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ucode_seq i_ucode_seq (
    .clk(clk), .rst(rst), .opcode(opcode), .carry(carry), .upc(upc), .ctrl(ctrl)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Walks one instruction from the first fetch step; expects upc==0x3F on entry.
  task automatic run_seq(input logic [3:0] op, input logic cy, input string tag,
                         input int n, input logic [5:0] exp [6]);
    opcode = op;
    carry  = cy;
    for (int i = 0; i < n; i++) begin
      chk(upc == exp[i], tag, upc, exp[i]);
      chk(ctrl[7] == (exp[i] == 6'h3E), "R2 ir_ld", ctrl[7], exp[i] == 6'h3E);
      chk(ctrl[6] == (exp[i] == 6'h1A), "R9 mem_wr", ctrl[6], exp[i] == 6'h1A);
      chk(ctrl[9] == (exp[i] == 6'h20 || exp[i] == 6'h22), "R6 pc_ld", ctrl[9],
          exp[i] == 6'h20 || exp[i] == 6'h22);
      if (exp[i] >= 6'h10 && exp[i] <= 6'h17)
        chk(ctrl[4] && ctrl[3:0] == exp[i][3:0], "R4 alu", {ctrl[4], ctrl[3:0]},
            {1'b1, exp[i][3:0]});
      // R3 / R7: disturb inputs after their sampling step
      if (i == 2) begin
        opcode = ~op;
        if (op != 4'h9) carry = ~cy;
      end
      if (i == 3) carry = ~cy;
      @(negedge clk);
    end
    chk(upc == 6'h3F, {tag, " return"}, upc, 6'h3F);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(upc == 6'h3F, "R1 reset upc", upc, 6'h3F);
    chk(ctrl[5] && ctrl[8], "R1 reset ctrl", {ctrl[5], ctrl[8]}, 2'b11);
    rst = 1'b0;
    chk(upc == 6'h3F, "R1 first cycle", upc, 6'h3F);
  endtask

  task automatic t_alu;
    for (int k = 0; k < 8; k++) begin
      logic [5:0] s [6];
      s = '{6'h3F, 6'h3E, 6'(k), 6'(16 + k), 6'h3F, 6'h3F};
      run_seq(4'(k), k[0], "R4 alu seq", 4, s);
    end
  endtask

  task automatic t_jmpu;
    logic [5:0] s [6];
    s = '{6'h3F, 6'h3E, 6'h08, 6'h1F, 6'h20, 6'h3F};
    run_seq(4'h8, 1'b0, "R5 jmpu", 5, s);
    run_seq(4'h8, 1'b1, "R7 jmpu carry", 5, s);
  endtask

  task automatic t_jmpc;
    logic [5:0] s [6];
    s = '{6'h3F, 6'h3E, 6'h09, 6'h21, 6'h22, 6'h3F};
    run_seq(4'h9, 1'b1, "R6 jmpc taken", 5, s);
    s = '{6'h3F, 6'h3E, 6'h09, 6'h3F, 6'h3F, 6'h3F};
    run_seq(4'h9, 1'b0, "R6 jmpc skip", 3, s);
  endtask

  task automatic t_swap_cpy;
    logic [5:0] s [6];
    s = '{6'h3F, 6'h3E, 6'h0A, 6'h18, 6'h3F, 6'h3F};
    run_seq(4'hA, 1'b0, "R8 swap", 4, s);
    s = '{6'h3F, 6'h3E, 6'h0B, 6'h3F, 6'h3F, 6'h3F};
    run_seq(4'hB, 1'b1, "R8 copy", 3, s);
  endtask

  task automatic t_mem;
    logic [5:0] s [6];
    s = '{6'h3F, 6'h3E, 6'h0C, 6'h19, 6'h1A, 6'h3F};
    run_seq(4'hC, 1'b0, "R9 write", 5, s);
    s = '{6'h3F, 6'h3E, 6'h0D, 6'h1B, 6'h1C, 6'h3F};
    run_seq(4'hD, 1'b1, "R9 read", 5, s);
  endtask

  task automatic t_io;
    logic [5:0] s [6];
    s = '{6'h3F, 6'h3E, 6'h0E, 6'h1D, 6'h3F, 6'h3F};
    run_seq(4'hE, 1'b0, "R10 input", 4, s);
    s = '{6'h3F, 6'h3E, 6'h0F, 6'h1E, 6'h3F, 6'h3F};
    run_seq(4'hF, 1'b1, "R10 output", 4, s);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_alu();
    t_jmpu();
    t_jmpc();
    t_swap_cpy();
    t_mem();
    t_io();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule